// File: doc/BRIEF.md
# Latched Time-of-Day Counter

This block keeps a 24-bit binary time-of-day count that advances from a slow external tick taken from the mains supply. The tick is synchronized and edge-detected, then divided by six or by five, depending on whether the supply runs at 60 Hz or 50 Hz. The count therefore steps in tenths of a second. Software reaches the count one byte at a time through a small register port with three byte addresses: low, middle and high.

Two mechanisms keep those byte accesses consistent:

- **Reading.** A read of the high byte freezes a copy of the whole count. The middle and low reads then come from that copy, and the low read releases it.
- **Writing.** A write of the high byte stops the count. It stays stopped until the low byte is written, so a new value cannot be corrupted by a carry between byte writes.

A separate 24-bit alarm value is written through the same byte addresses while a select input is high. The block emits a one-cycle strobe when an increment lands on that value.

Top module: `tod_clock`

## Requirements
- R1: The count is 24 bits and is addressed as bytes: address 0 is the low byte, 1 the middle byte and 2 the high byte. A read of address 3 returns 0x00. Each advance adds exactly one, and 0xFFFFFF wraps to 0x000000.
- R2: Each rising edge of `tick_in` is counted once, however long the input stays high. With `rate_sel`=0 the count advances once per 6 counted edges, and with `rate_sel`=1 once per 5 counted edges.
- R3: A read of address 2 while no copy is held returns the live high byte and captures all 24 bits. While the copy is held, reads of addresses 2, 1 and 0 return the captured bytes even if the count moves on.
- R4: A read of address 0 releases the held copy. Later reads return the live count again.
- R5: A write to address 2 with `alarm_sel`=0 loads the high byte and stops counting. Ticks arriving while stopped are discarded and clear the divide-by prescaler.
- R6: A write to address 1 with `alarm_sel`=0 loads the middle byte. A write to address 0 with `alarm_sel`=0 loads the low byte and resumes counting from a cleared prescaler.
- R7: With `alarm_sel`=1, writes to addresses 0 to 2 load the alarm bytes. The count is neither changed nor stopped by them.
- R8: `alarm_o` is high for exactly one cycle, in the cycle the count first shows a value reached by an increment that equals the alarm value. Loading the count to the alarm value by writes gives no strobe.
- R9: After reset the count is 0x000000, the alarm value is 0x000000, counting runs, no copy is held and `alarm_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | Asynchronous mains-rate tick |
| rate_sel | input | 1 | 0: 60 Hz ticks (divide by 6), 1: 50 Hz ticks (divide by 5) |
| alarm_sel | input | 1 | 1: byte writes go to the alarm value |
| rd_en | input | 1 | Read strobe for the byte at `addr` |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| addr | input | 2 | Byte address: 0 low, 1 middle, 2 high |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high, else 0 |
| alarm_o | output | 1 | One-cycle alarm strobe |

## Verification
The bench goes after a carry from the low into the middle byte while a snapshot is held. A design that dropped the copy, or refreshed it on a later read, would return a torn value such as 0x0102FF. Long tick pulses are used to expose a level-sensitive counter, which would advance many times per tick. Ticks are applied between the high and low writes, so a design without the halt would show an altered loaded value. An alarm write that reaches the running count, and a load that equals the alarm value, catch designs that stop on alarm writes or strobe on writes. The wrap from 0xFFFFFF to zero is also checked against the reset alarm value of zero.

// File: rtl/tod_pkg.sv
// Package: shared widths and the byte-select encoding of the
// time-of-day block. Assumes a three-byte register window.
package tod_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_MID  = 2'd1,
        SEL_HI   = 2'd2,
        SEL_NONE = 2'd3
    } tod_sel_e;
endpackage

// File: rtl/tod_tick_sync.sv
// Module: tod_tick_sync
// Brings the asynchronous mains tick into the clock domain through a
// flop chain, detects its rising edge, and divides edges by DIV_A
// (rate_sel=0) or DIV_B (rate_sel=1) to form a one-cycle step.
// Assumes tick edges are far slower than clk. While hold is high,
// edges are discarded and the prescaler stays cleared.
module tod_tick_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_A       = 6,
    parameter int DIV_B       = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic rate_sel,
    input  logic hold,
    output logic step
);
    localparam int DMAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int PW   = (DMAX > 2) ? $clog2(DMAX) : 1;

    logic [SYNC_STAGES:0] sh_q;
    logic [PW-1:0]        pre_q;
    logic [PW-1:0]        lim;
    logic                 rise;

    // Shift the tick through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], tick_in};
    end

    assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    assign lim  = rate_sel ? PW'(DIV_B - 1) : PW'(DIV_A - 1);

    // Count synchronized edges up to the selected limit.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)  pre_q <= '0;
        else if (rise)       pre_q <= (pre_q >= lim) ? '0 : pre_q + 1'b1;
    end

    // Emit a step on the edge that completes a division period.
    assign step = rise && !hold && (pre_q >= lim);
endmodule

// File: rtl/tod_count_core.sv
// Module: tod_count_core
// Holds the running count, the halt flag and the alarm value. Byte
// writes either load the count (alarm_sel=0) or the alarm (alarm_sel=1).
// A high-byte count write halts, a low-byte count write resumes.
// Assumes step is already one cycle wide.
module tod_count_core
    import tod_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wr_en,
    input  logic             alarm_sel,
    input  tod_sel_e         sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic             halted,
    output logic             alarm_hit
);
    localparam int NB = CNT_W / BYTE_W;

    logic [CNT_W-1:0] cnt_q, cnt_sum, cnt_nxt;
    logic [CNT_W-1:0] alm_q, alm_nxt;
    logic             halt_q, halt_nxt, hit_q;
    logic             inc, wr_cnt;

    assign inc     = step && !halt_q;
    assign wr_cnt  = wr_en && !alarm_sel;
    assign cnt_sum = cnt_q + {{(CNT_W-1){1'b0}}, inc};

    // Overlay any written byte onto the incremented count or alarm.
    always_comb begin
        cnt_nxt = cnt_sum;
        alm_nxt = alm_q;
        for (int b = 0; b < NB; b++) begin
            if (wr_en && (int'(sel) == b)) begin
                if (alarm_sel) alm_nxt[b*BYTE_W +: BYTE_W] = wdata;
                else           cnt_nxt[b*BYTE_W +: BYTE_W] = wdata;
            end
        end
    end

    // Decide the next halt state from count writes.
    always_comb begin
        halt_nxt = halt_q;
        if (wr_cnt && sel == SEL_HI) halt_nxt = 1'b1;
        if (wr_cnt && sel == SEL_LO) halt_nxt = 1'b0;
    end

    // Register count, alarm, halt flag and the alarm strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            alm_q  <= '0;
            halt_q <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            alm_q  <= alm_nxt;
            halt_q <= halt_nxt;
            hit_q  <= inc && !wr_cnt && (cnt_sum == alm_q);
        end
    end

    assign count     = cnt_q;
    assign halted    = halt_q;
    assign alarm_hit = hit_q;
endmodule

// File: rtl/tod_read_latch.sv
// Module: tod_read_latch
// Gives software a coherent multi-byte read. A high-byte read with no
// copy held captures the count; reads are then served from the copy
// until a low-byte read releases it. Read data is combinational.
module tod_read_latch
    import tod_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  tod_sel_e         sel,
    input  logic [CNT_W-1:0] count,
    output logic [BYTE_W-1:0] rdata,
    output logic             held,
    output logic [CNT_W-1:0] snap
);
    logic [CNT_W-1:0] snap_q, src;
    logic             held_q;

    // Capture on the first high read, release on a low read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            held_q <= 1'b0;
        end else if (rd_en && sel == SEL_HI && !held_q) begin
            snap_q <= count;
            held_q <= 1'b1;
        end else if (rd_en && sel == SEL_LO) begin
            held_q <= 1'b0;
        end
    end

    assign src = held_q ? snap_q : count;

    // Select the addressed byte of the live or held value.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_LO:   rdata = src[0*BYTE_W +: BYTE_W];
                SEL_MID:  rdata = src[1*BYTE_W +: BYTE_W];
                SEL_HI:   rdata = src[2*BYTE_W +: BYTE_W];
                default:  rdata = '0;
            endcase
        end
    end

    assign held = held_q;
    assign snap = snap_q;
endmodule

// File: rtl/tod_clock.sv
// Module: tod_clock (top)
// Time-of-day counter with mains tick input, coherent byte reads,
// halting byte writes and an alarm strobe. Assumes one register
// access per cycle and a tick much slower than clk.
module tod_clock
    import tod_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_60      = 6,
    parameter int DIV_50      = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_in,
    input  logic       rate_sel,
    input  logic       alarm_sel,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       alarm_o
);
    tod_sel_e         sel;
    logic             step_w, halted_w, held_w;
    logic [CNT_W-1:0] count_w, snap_w;

    assign sel = tod_sel_e'(addr);

    tod_tick_sync #(
        .SYNC_STAGES(SYNC_STAGES), .DIV_A(DIV_60), .DIV_B(DIV_50)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
        .rate_sel(rate_sel), .hold(halted_w), .step(step_w)
    );

    tod_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .step(step_w), .wr_en(wr_en),
        .alarm_sel(alarm_sel), .sel(sel), .wdata(wdata),
        .count(count_w), .halted(halted_w), .alarm_hit(alarm_o)
    );

    tod_read_latch #(.CNT_W(CNT_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(sel),
        .count(count_w), .rdata(rdata), .held(held_w), .snap(snap_w)
    );
endmodule

// File: rtl/tod_clock_chk.sv
// Module: tod_clock_chk
// Temporal checks on the time-of-day block, bound into every tod_clock.
module tod_clock_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             alarm_sel,
    input logic [1:0]       addr,
    input logic [CNT_W-1:0] count,
    input logic             halted,
    input logic             held,
    input logic [CNT_W-1:0] snap,
    input logic             alarm_o
);
    // R1: without a write the count holds or moves up by exactly one.
    a_r1_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (count == $past(count) || count == $past(count) + 1'b1));

    // R3: a held copy never changes.
    a_r3_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(snap));

    // R5: a high count write leaves the counter halted.
    a_r5_high_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !alarm_sel && addr == 2'd2) |=> halted);

    // R5: while halted and not written, the count is frozen.
    a_r5_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !wr_en) |=> $stable(count));

    // R6: a low count write resumes counting.
    a_r6_low_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !alarm_sel && addr == 2'd0) |=> !halted);

    // R7: alarm writes never halt a running count.
    a_r7_alarm_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && alarm_sel && !halted) |=> !halted);

    // R8: the strobe lasts one cycle and only follows a count change.
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |=> !alarm_o);
    a_r8_after_change: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> (count != $past(count)));
endmodule

bind tod_clock tod_clock_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .alarm_sel(alarm_sel),
    .addr(addr), .count(count_w), .halted(halted_w), .held(held_w),
    .snap(snap_w), .alarm_o(alarm_o)
);

// File: tb/tb_tod_clock.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor pops and
// compares them at the falling edge while rd_en is high.
module tb_tod_clock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0, rate_sel = 1'b0, alarm_sel = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       alarm_o;

    int checks = 0, failures = 0, pulses = 0;
    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    tod_clock dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .rate_sel(rate_sel),
        .alarm_sel(alarm_sel), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .alarm_o(alarm_o)
    );

    // Monitor: compare each read against the queued expectation.
    always @(negedge clk) begin
        if (alarm_o) pulses++;
        if (rd_en) begin
            checks++;
            if (q_exp.size() == 0) begin
                failures++;
                $display("FAIL unexpected read: actual %02h expected none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (rdata !== e) begin
                    failures++;
                    $display("FAIL %s: actual %02h expected %02h", t, rdata, e);
                end
            end
        end
    end

    task automatic step_drv();
        @(posedge clk); #2;
    endtask

    task automatic check_eq(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        step_drv();
        addr = a; rd_en = 1'b1;
        step_drv();
        rd_en = 1'b0;
    endtask

    task automatic rd_all(logic [23:0] v, string tag);
        rd(2'd2, v[23:16], tag);
        rd(2'd1, v[15:8], tag);
        rd(2'd0, v[7:0], tag);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        step_drv();
        addr = a; wdata = d; wr_en = 1'b1;
        step_drv();
        wr_en = 1'b0;
    endtask

    task automatic load(logic [23:0] v);
        wr(2'd2, v[23:16]);
        wr(2'd1, v[15:8]);
        wr(2'd0, v[7:0]);
    endtask

    task automatic ticks(int n, int hi_cycles);
        for (int i = 0; i < n; i++) begin
            step_drv(); tick_in = 1'b1;
            repeat (hi_cycles) step_drv();
            tick_in = 1'b0;
            repeat (4) step_drv();
        end
    endtask

    // Watchdog: a hung run is a failure that still reports.
    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) step_drv();
        rst_n = 1'b1;
        step_drv();
        // R9: reset state.
        check_eq(int'(alarm_o), 0, "R9 alarm low");
        rd_all(24'h000000, "R9 count zero");

        // R5/R6: ticks during a staged load must not advance it.
        wr(2'd2, 8'h12);
        ticks(12, 3);
        wr(2'd1, 8'h34);
        ticks(6, 3);
        wr(2'd0, 8'h56);
        rd_all(24'h123456, "R5 halted load");

        // R2: divide by six, then by five.
        ticks(5, 3);
        rd_all(24'h123456, "R2 five of six");
        ticks(1, 3);
        rd_all(24'h123457, "R6 resumed");
        rate_sel = 1'b1;
        ticks(5, 3);
        rd_all(24'h123458, "R2 divide five");
        ticks(5, 20);
        rd_all(24'h123459, "R2 long pulses once");

        // R3/R4: snapshot across a carry.
        load(24'h0101FF);
        rd(2'd2, 8'h01, "R3 high capture");
        ticks(5, 3);
        rd(2'd1, 8'h01, "R3 held mid");
        rd(2'd2, 8'h01, "R3 held high");
        rd(2'd0, 8'hFF, "R3 held low");
        rd(2'd0, 8'h00, "R4 live low");
        rd(2'd1, 8'h02, "R4 live mid");
        rd(2'd3, 8'h00, "R1 unused address");

        // R1/R8: wrap to zero hits the reset alarm value.
        load(24'hFFFFFF);
        check_eq(pulses, 0, "R8 no strobe before wrap");
        ticks(5, 3);
        rd_all(24'h000000, "R1 wrap");
        check_eq(pulses, 1, "R8 strobe on wrap to alarm zero");

        // R7: alarm writes leave the count running.
        alarm_sel = 1'b1;
        wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h03);
        alarm_sel = 1'b0;
        ticks(5, 3);
        rd_all(24'h000001, "R7 count unchanged and running");
        ticks(10, 3);
        rd_all(24'h000003, "R8 count at alarm");
        check_eq(pulses, 2, "R8 strobe at alarm");
        ticks(5, 3);
        check_eq(pulses, 2, "R8 single strobe");

        // R8: loading the alarm value by writes gives no strobe.
        load(24'h000003);
        repeat (3) step_drv();
        check_eq(pulses, 2, "R8 no strobe on write");
        rd_all(24'h000003, "R6 loaded value");

        check_eq(q_exp.size(), 0, "R3 scoreboard drained");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule